// File: doc/BRIEF.md
# Dual-Source Timing Divider Chain

This block derives every slow timing reference of a small controller from one system clock. A four-count prescaler, advanced by a one-cycle high-frequency tick (`fc_tick`), drives a 21-stage binary divider. Stages 1 to 6 always count prescaler overflows. Stage 7 takes its input either from the carry out of stage 6 or from rising edges of a low-frequency clock (`fs_in`), which is brought into the system domain through a synchronizer. Every stage overflow is presented as a one-cycle enable strobe, never as a derived clock, and six of the stages are also brought out under functional names for the timer, serial, divider-output, time-base, warm-up and watchdog consumers.

Which clock feeds stage 7 is set by a three-state source machine. From the `slow_mode` input and a select bit held in a write-only control register, it moves between SRC_FAST (stage 7 fed from stage 6), SRC_ALT (stage 7 fed from fs edges, stages 1 to 6 still running) and SRC_SLOW (stage 7 fed from fs edges, stages 1 to 6 held at zero). The transitions are: any state goes to SRC_SLOW when `slow_mode` is 1; any state goes to SRC_ALT when `slow_mode` is 0 and the select bit is 1; any state goes to SRC_FAST when both are 0. Reset places the machine in SRC_FAST. A release from STOP mode (`stop_rel`) and reset both zero all 21 divider stages, but neither touches the prescaler, so its phase carries across.

Top module: `tgen_divchain`

## Requirements
- R1: Each `fc_tick` advances a two-bit prescaler, and the stage-1 strobe (`taps_o[0]`) fires once per 8 ticks. The prescaler is cleared neither by `rst_n` nor by `stop_rel`.
- R2: In SRC_FAST or SRC_ALT, the strobe of stage k (k = 1..6, bit `taps_o[k-1]`) fires once per 4·2^k `fc_tick`s and lasts one cycle. A strobe of stage k > 1 only occurs together with a strobe of stage k-1.
- R3: In SRC_FAST, stage 7 counts the overflows of stage 6. In SRC_ALT and SRC_SLOW, it counts the synchronized rising edges of `fs_in`.
- R4: Stage k (k = 7..21, bit `taps_o[k-1]`) strobes once per 2^(k-6) inputs to stage 7.
- R5: `fs_in` passes through two flops and an edge detector. Only a 0-to-1 change counts, it counts once, and a steady level adds nothing.
- R6: A write (`ctrl_we` = 1) stores only bit 4 of `ctrl_wdata` as the fs-select bit (1 = fs source). All other bits have no effect. The new source takes effect two cycles after the write.
- R7: In SRC_SLOW, stages 1 to 6 are held at zero and produce no strobes.
- R8: A `stop_rel` pulse zeroes stages 1 to 21 in one cycle. No strobe appears in that cycle or in the next.
- R9: While `rst_n` is 0, all strobes are 0. Reset clears the divider, the synchronizer, the select bit (back to the fc source) and the source machine.
- R10: The named strobes equal fixed stage taps: `ser_src_o` stage 5, `tmr_src_o` stage 7, `dvo_pulse_o` stage 12, `tbt_src_o` stage 14, `warm_src_o` stage 20, `wdt_src_o` stage 21.
- R11: The source machine follows SRC_SLOW when `slow_mode` is 1, otherwise SRC_ALT or SRC_FAST by the select bit. Leaving SRC_SLOW with the select bit set restarts stages 1 to 6 while stage 7 stays on fs edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fc_tick | input | 1 | One-cycle high-frequency clock enable |
| fs_in | input | 1 | Low-frequency clock level, asynchronous |
| stop_rel | input | 1 | One-cycle STOP-release pulse, clears the divider |
| slow_mode | input | 1 | 1 selects low-power operation from fs |
| ctrl_we | input | 1 | Control register write enable |
| ctrl_wdata | input | 8 | Control write data, bit 4 = fs select |
| taps_o | output | 21 | Stage overflow strobes, bit k-1 = stage k |
| ser_src_o | output | 1 | Serial source strobe |
| tmr_src_o | output | 1 | Timer source strobe |
| dvo_pulse_o | output | 1 | Divider output pulse strobe |
| tbt_src_o | output | 1 | Time base source strobe |
| warm_src_o | output | 1 | Warm-up counter strobe |
| wdt_src_o | output | 1 | Watchdog source strobe |

## Verification
Two events can land in the same cycle: a STOP release and a stage overflow that is about to strobe. The bench finds a stage-1 strobe and then raises `stop_rel` exactly eight cycles later, when the next one is due. It checks that the clear wins and that the cycle after is also silent. In a second case, a prescaler phase left by a partial tick count is carried through both a STOP release and a reset, and the bench measures the delay to the first stage-1 strobe. A behavioural model checks every strobe on every clock, including the cycles in which source changes and fs edges meet.

// File: rtl/tg_pkg.sv
package tg_pkg;

    typedef enum logic [1:0] {
        SRC_FAST = 2'd0,
        SRC_ALT  = 2'd1,
        SRC_SLOW = 2'd2
    } src_state_e;

endpackage

// File: rtl/tg_prescaler.sv
module tg_prescaler #(
    parameter int W = 2
) (
    input  logic clk,
    input  logic tick,
    output logic ov
);
    // Kept out of reset on purpose: phase survives reset and STOP release.
    logic [W-1:0] cnt_q = '0;

    always_ff @(posedge clk) begin
        if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign ov = tick & (&cnt_q);

endmodule

// File: rtl/tg_fs_sync.sv
module tg_fs_sync #(
    parameter int N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fs_in,
    output logic rise
);
    logic [N:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= {sh_q[N-1:0], fs_in};
        end
    end

    assign rise = sh_q[N-1] & ~sh_q[N];

endmodule

// File: rtl/tg_div_seg.sv
module tg_div_seg #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         clr,
    input  logic         hold,
    output logic [W-1:0] taps
);
    logic [W-1:0] cnt_q;
    logic         adv;

    assign adv = inc & ~clr & ~hold;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr | hold) begin
            cnt_q <= '0;
        end else if (adv) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    for (genvar i = 0; i < W; i++) begin : g_tap
        assign taps[i] = adv & (&cnt_q[i:0]);
    end

endmodule

// File: rtl/tg_src_fsm.sv
module tg_src_fsm
    import tg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       slow_mode,
    input  logic       sel_fs,
    output src_state_e state_q,
    output logic       use_fs,
    output logic       hold_low
);
    src_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SRC_FAST: begin
                if (slow_mode)   state_d = SRC_SLOW;
                else if (sel_fs) state_d = SRC_ALT;
            end
            SRC_ALT: begin
                if (slow_mode)    state_d = SRC_SLOW;
                else if (!sel_fs) state_d = SRC_FAST;
            end
            SRC_SLOW: begin
                if (!slow_mode) state_d = sel_fs ? SRC_ALT : SRC_FAST;
            end
            default: state_d = SRC_FAST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SRC_FAST;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            SRC_FAST: begin use_fs = 1'b0; hold_low = 1'b0; end
            SRC_ALT:  begin use_fs = 1'b1; hold_low = 1'b0; end
            SRC_SLOW: begin use_fs = 1'b1; hold_low = 1'b1; end
            default:  begin use_fs = 1'b0; hold_low = 1'b0; end
        endcase
    end

endmodule

// File: rtl/tgen_divchain.sv
module tgen_divchain
    import tg_pkg::*;
#(
    parameter int PRE_W       = 2,
    parameter int N_STAGES    = 21,
    parameter int MUX_STAGE   = 7,
    parameter int CTRL_W      = 8,
    parameter int SEL_BIT     = 4,
    parameter int SYNC_STAGES = 2,
    parameter int SER_STAGE   = 5,
    parameter int TMR_STAGE   = 7,
    parameter int DVO_STAGE   = 12,
    parameter int TBT_STAGE   = 14,
    parameter int WARM_STAGE  = 20,
    parameter int WDT_STAGE   = 21
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fc_tick,
    input  logic                fs_in,
    input  logic                stop_rel,
    input  logic                slow_mode,
    input  logic                ctrl_we,
    input  logic [CTRL_W-1:0]   ctrl_wdata,
    output logic [N_STAGES-1:0] taps_o,
    output logic                ser_src_o,
    output logic                tmr_src_o,
    output logic                dvo_pulse_o,
    output logic                tbt_src_o,
    output logic                warm_src_o,
    output logic                wdt_src_o
);
    localparam int LO_W = MUX_STAGE - 1;
    localparam int HI_W = N_STAGES - LO_W;

    logic            sel_q;
    logic            unused_wdata;
    logic            pre_ov;
    logic            fs_rise;
    logic            use_fs;
    logic            hold_low;
    logic            feed7;
    src_state_e      src_state;
    logic [LO_W-1:0] lo_taps;
    logic [HI_W-1:0] hi_taps;

    assign unused_wdata = ^ctrl_wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= 1'b0;
        end else if (ctrl_we) begin
            sel_q <= ctrl_wdata[SEL_BIT];
        end
    end

    tg_prescaler #(.W(PRE_W)) u_pre (
        .clk  (clk),
        .tick (fc_tick),
        .ov   (pre_ov)
    );

    tg_fs_sync #(.N(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .fs_in (fs_in),
        .rise  (fs_rise)
    );

    tg_src_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .slow_mode (slow_mode),
        .sel_fs    (sel_q),
        .state_q   (src_state),
        .use_fs    (use_fs),
        .hold_low  (hold_low)
    );

    tg_div_seg #(.W(LO_W)) u_lo (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (pre_ov),
        .clr   (stop_rel),
        .hold  (hold_low),
        .taps  (lo_taps)
    );

    assign feed7 = use_fs ? fs_rise : lo_taps[LO_W-1];

    tg_div_seg #(.W(HI_W)) u_hi (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (feed7),
        .clr   (stop_rel),
        .hold  (1'b0),
        .taps  (hi_taps)
    );

    assign taps_o      = {hi_taps, lo_taps};
    assign ser_src_o   = taps_o[SER_STAGE-1];
    assign tmr_src_o   = taps_o[TMR_STAGE-1];
    assign dvo_pulse_o = taps_o[DVO_STAGE-1];
    assign tbt_src_o   = taps_o[TBT_STAGE-1];
    assign warm_src_o  = taps_o[WARM_STAGE-1];
    assign wdt_src_o   = taps_o[WDT_STAGE-1];

endmodule

// File: rtl/tg_checker.sv
module tg_checker
    import tg_pkg::*;
#(
    parameter int N_STAGES = 21,
    parameter int LO_W     = 6
) (
    input logic                clk,
    input logic                rst_n,
    input logic                stop_rel,
    input logic                slow_mode,
    input logic                fs_rise,
    input logic                use_fs,
    input src_state_e          state_q,
    input logic [N_STAGES-1:0] taps
);
    for (genvar i = 1; i < N_STAGES; i++) begin : g_nest
        if (i == LO_W) begin : g_mux
            assert_mux_nest_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (taps[i] && !use_fs) |-> taps[i-1]);
        end else if (i < LO_W) begin : g_lo
            assert_lo_nest_R2: assert property (@(posedge clk) disable iff (!rst_n)
                taps[i] |-> taps[i-1]);
        end else begin : g_hi
            assert_hi_nest_R4: assert property (@(posedge clk) disable iff (!rst_n)
                taps[i] |-> taps[i-1]);
        end
    end

    assert_fs_feed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (use_fs && taps[LO_W]) |-> fs_rise);

    assert_rise_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fs_rise |=> !fs_rise);

    assert_slow_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SRC_SLOW) |-> (taps[LO_W-1:0] == '0));

    assert_stop_now_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_rel |-> (taps == '0));

    assert_stop_next_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_rel |=> (taps == '0));

    assert_slow_enter_R11: assert property (@(posedge clk) disable iff (!rst_n)
        slow_mode |=> (state_q == SRC_SLOW));

    always @(posedge clk) begin
        if (rst_n == 1'b0) begin
            assert_reset_quiet_R9: assert (taps == '0);
        end
    end

endmodule

bind tgen_divchain tg_checker #(
    .N_STAGES (N_STAGES),
    .LO_W     (LO_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .stop_rel  (stop_rel),
    .slow_mode (slow_mode),
    .fs_rise   (fs_rise),
    .use_fs    (use_fs),
    .state_q   (src_state),
    .taps      (taps_o)
);

// File: tb/tgen_divchain_tb.sv
`timescale 1ns/100ps
module tgen_divchain_tb;

    localparam int NS = 21;

    logic          clk = 1'b0;
    logic          rst_n = 1'b1;
    logic          fc_tick = 1'b0;
    logic          fs_in = 1'b0;
    logic          stop_rel = 1'b0;
    logic          slow_mode = 1'b0;
    logic          ctrl_we = 1'b0;
    logic [7:0]    ctrl_wdata = 8'h00;
    logic [NS-1:0] taps_o;
    logic ser_src_o, tmr_src_o, dvo_pulse_o, tbt_src_o, warm_src_o, wdt_src_o;

    int n_checks = 0;
    int n_fail   = 0;
    int fc_mode  = 0;
    int fs_mode  = 0;
    int fs_div   = 0;
    int cnts[NS];

    // behavioural reference state
    int m_pre = 0, m_lo = 0, m_hi = 0, m_st = 0;
    bit m_s1 = 0, m_s2 = 0, m_s3 = 0, m_sel = 0;

    always #2.5 clk = ~clk;

    tgen_divchain u_dut (
        .clk(clk), .rst_n(rst_n), .fc_tick(fc_tick), .fs_in(fs_in),
        .stop_rel(stop_rel), .slow_mode(slow_mode), .ctrl_we(ctrl_we),
        .ctrl_wdata(ctrl_wdata), .taps_o(taps_o), .ser_src_o(ser_src_o),
        .tmr_src_o(tmr_src_o), .dvo_pulse_o(dvo_pulse_o), .tbt_src_o(tbt_src_o),
        .warm_src_o(warm_src_o), .wdt_src_o(wdt_src_o)
    );

    always @(negedge clk) begin
        case (fc_mode)
            1: fc_tick = 1'b1;
            2: fc_tick = ~fc_tick;
            default: fc_tick = 1'b0;
        endcase
        fs_div++;
        case (fs_mode)
            1: fs_in = ~fs_in;
            2: if (fs_div % 4 == 0) fs_in = ~fs_in;
            default: ;
        endcase
    end

    function automatic logic [NS-1:0] exp_taps();
        logic [NS-1:0] e;
        bit ov, run_lo, feed;
        e = '0;
        ov = fc_tick && (m_pre == 3);
        run_lo = ov && (m_st != 2) && !stop_rel && rst_n;
        for (int k = 1; k <= 6; k++)
            if (run_lo && (m_lo % (1 << k)) == (1 << k) - 1) e[k-1] = 1'b1;
        feed = (m_st != 0) ? (m_s2 && !m_s3) : e[5];
        feed = feed && !stop_rel && rst_n;
        for (int k = 7; k <= NS; k++)
            if (feed && (m_hi % (1 << (k-6))) == (1 << (k-6)) - 1) e[k-1] = 1'b1;
        return e;
    endfunction

    always @(posedge clk) begin
        bit ov, feed;
        int nst;
        ov   = fc_tick && (m_pre == 3);
        feed = (m_st != 0) ? (m_s2 && !m_s3) : (ov && m_st == 0 && m_lo == 63);
        if (fc_tick) m_pre = (m_pre + 1) % 4;
        if (!rst_n) begin
            m_lo = 0; m_hi = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0; m_sel = 0; m_st = 0;
        end else begin
            nst = slow_mode ? 2 : (m_sel ? 1 : 0);
            if (stop_rel || m_st == 2) m_lo = 0;
            else if (ov) m_lo = (m_lo + 1) % 64;
            if (stop_rel) m_hi = 0;
            else if (feed) m_hi = (m_hi + 1) % 32768;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = fs_in;
            if (ctrl_we) m_sel = ctrl_wdata[4];
            m_st = nst;
        end
    end

    // per-cycle comparison against the model
    always @(posedge clk) begin
        logic [NS-1:0] e;
        logic [5:0] ne, na;
        bit ok;
        #1;
        e  = exp_taps();
        ok = 1;
        if (taps_o[5:0] !== e[5:0]) begin
            ok = 0;
            $display("FAIL R2 low strobes at %0t: got %b expected %b", $time, taps_o[5:0], e[5:0]);
        end
        if (taps_o[NS-1:6] !== e[NS-1:6]) begin
            ok = 0;
            $display("FAIL R4 high strobes at %0t: got %b expected %b", $time, taps_o[NS-1:6], e[NS-1:6]);
        end
        ne = {e[4], e[6], e[11], e[13], e[19], e[20]};
        na = {ser_src_o, tmr_src_o, dvo_pulse_o, tbt_src_o, warm_src_o, wdt_src_o};
        if (na !== ne) begin
            ok = 0;
            $display("FAIL R10 named strobes at %0t: got %b expected %b", $time, na, ne);
        end
        n_checks++;
        if (!ok) n_fail++;
    end

    task automatic chk(input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic count_win(input int n);
        for (int k = 0; k < NS; k++) cnts[k] = 0;
        repeat (n) begin
            @(posedge clk); #1;
            for (int k = 0; k < NS; k++) cnts[k] += int'(taps_o[k]);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic write_ctrl(input logic [7:0] v);
        @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = v;
        @(negedge clk); ctrl_we = 1'b0; ctrl_wdata = 8'h00;
        settle(1);
    endtask

    task automatic finish_run();
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        int n;
        fc_mode = 1; fs_mode = 2;
        #1 rst_n = 1'b0;
        settle(6);
        chk("R9 strobes held in reset", int'(taps_o), 0);
        chk("R9 named strobes in reset", int'(wdt_src_o | tmr_src_o | ser_src_o), 0);
        @(negedge clk) rst_n = 1'b1;

        // fc source, fs toggling but ignored
        settle(16); count_win(4096);
        chk("R1 stage1 per 8 ticks", cnts[0], 512);
        chk("R2 stage6 ratio", cnts[5], 16);
        chk("R3 stage7 from stage6", cnts[6], 8);
        chk("R4 stage8 ratio", cnts[7], 4);

        fc_mode = 2;
        settle(16); count_win(4096);
        chk("R1 stage1 with half-rate ticks", cnts[0], 256);

        fc_mode = 1;
        write_ctrl(8'hEF);
        settle(16); count_win(4096);
        chk("R6 bits other than 4 ignored", cnts[6], 8);

        write_ctrl(8'h10);
        settle(16); count_win(4096);
        chk("R3 stage7 from fs edges", cnts[6], 256);
        chk("R2 low stages run in alt source", cnts[5], 16);

        fs_mode = 0;
        settle(16); count_win(1024);
        chk("R5 steady fs level adds nothing", cnts[6], 0);

        @(negedge clk) slow_mode = 1'b1;
        fs_mode = 2;
        settle(16); count_win(4096);
        chk("R7 stage1 silent in slow", cnts[0], 0);
        chk("R7 stage6 silent in slow", cnts[5], 0);
        chk("R3 stage7 from fs in slow", cnts[6], 256);

        fs_mode = 1;
        settle(16); count_win(65536);
        chk("R4 stage21 ratio", cnts[20], 1);
        chk("R4 stage14 ratio", cnts[13], 128);

        @(negedge clk) slow_mode = 1'b0;
        settle(16); count_win(4096);
        chk("R11 low stages restart after slow", cnts[0], 512);
        chk("R11 stage7 stays on fs", cnts[6], 1024);

        // STOP release landing on a due stage-1 strobe
        write_ctrl(8'h00);
        fs_mode = 2;
        settle(16);
        do begin @(posedge clk); #1; end while (!taps_o[0]);
        repeat (7) @(posedge clk);
        @(negedge clk) stop_rel = 1'b1;
        @(posedge clk); #1;
        chk("R8 clear wins over due strobe", int'(taps_o), 0);
        @(negedge clk) stop_rel = 1'b0;
        @(posedge clk); #1;
        chk("R8 no strobe after clear", int'(taps_o), 0);

        // prescaler phase carried across STOP release and reset
        write_ctrl(8'h10);
        settle(8);
        do begin @(posedge clk); #1; end while (!taps_o[0]);
        repeat (3) @(posedge clk);
        #1 fc_mode = 0;
        @(negedge clk) stop_rel = 1'b1;
        @(negedge clk) stop_rel = 1'b0; rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1 fc_mode = 1;
        n = 0;
        do begin @(posedge clk); #1; n++; end while (!taps_o[0] && n < 50);
        chk("R1 prescaler phase survives clear", n, 5);

        settle(16); count_win(4096);
        chk("R9 reset returns to fc source", cnts[6], 8);

        finish_run();
    end

endmodule